// File: doc/BRIEF.md
# Brightness-Controlled 5x5 Light Grid

This block drives a square grid of lights, five rows of five, where every light has its own 4-bit brightness level. A host feeds it one byte per pixel. Each byte lands in the next column of the line being written. A next-line strobe moves the write position down one line, and the position wraps back to the top after the fifth line. A select strobe puts the write position back at the first column of the top line, the same way a host starts writing again after it selects the display.

The levels are held in registers inside the block. A free-running phase counter is shared by all 25 lights. Each light is driven high in the first L cycles of every 16-cycle period, where L is that light's level. Level 0 is dark and level 15 is on for 15 of every 16 cycles. The block has no panel multiplexing and no electrical drive. It gives one on/off output per light.

Top module: `led_grid_pwm`

## Requirements
- R1: After reset every pixel level is 0, every light output is low, and the write position is line 1, column 1.
- R2: A write stores bits [3:0] of the byte as the level of the pixel at the current line and column, then moves to the next column. Bits [7:4] have no effect. The pixel at 0-based line r and column c drives light_o[r*5+c].
- R3: Once five pixels have been written on a line, further writes are ignored and change no level until a next-line or select strobe.
- R4: A select strobe returns the write position to line 1, column 1 and leaves all stored levels unchanged. It takes priority over a write or next-line strobe in the same cycle, and those are dropped.
- R5: A next-line strobe moves to the following line with the column reset to 1. A next-line strobe on line 5 moves to line 1. A write in the same cycle as a next-line strobe is dropped.
- R6: Across any 16 consecutive cycles, each light is high in exactly L of them, where L is its stored level. Level 0 is never high, and level 15 is high for 15 of 16 cycles.
- R7: All lights share one PWM phase. When a light of level a is high, every light of level b >= a is also high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Select strobe; returns write position to the top-left |
| next_line_i | input | 1 | Advance to the next line, wrapping after the last |
| wr_en_i | input | 1 | Write strobe for wr_data_i |
| wr_data_i | input | 8 | Pixel byte; low nibble is the level |
| light_o | output | 25 | One PWM output per light, index line*5+column |

## Verification
The bench builds the block with its default parameters: five lines of five columns, 4-bit levels and 8-bit data. At this size a short stimulus sequence reaches the full-line drop, the wrap from line 5 to line 1, and the 15/16 duty at maximum level. Each 16-cycle duty window covers every phase counter value once, so a duty count per light does not depend on where the window starts. The same window is used to check that lights of different levels turn on in a nested order.

// File: rtl/led_grid_pkg.sv
package led_grid_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_SEL,
    ACT_NEXT,
    ACT_WR,
    ACT_DROP
  } ptr_act_e;
endpackage

// File: rtl/led_grid_ptr.sv
module led_grid_ptr
  import led_grid_pkg::*;
#(
  parameter int ROWS  = 5,
  parameter int COLS  = 5,
  localparam int NPIX  = ROWS * COLS,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = $clog2(COLS + 1),
  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             next_line_i,
  input  logic             wr_en_i,
  output logic             wr_vld_o,
  output logic [IDX_W-1:0] wr_idx_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_FULL = COL_W'(COLS);
  localparam logic [IDX_W-1:0] COLS_I   = IDX_W'(COLS);

  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  ptr_act_e         act;

  always_comb begin
    if (sel_i)                 act = ACT_SEL;
    else if (next_line_i)      act = ACT_NEXT;
    else if (wr_en_i)          act = (col_q < COL_FULL) ? ACT_WR : ACT_DROP;
    else                       act = ACT_IDLE;
  end

  assign wr_vld_o = (act == ACT_WR);
  assign wr_idx_o = IDX_W'(row_q) * COLS_I + IDX_W'(col_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      unique case (act)
        ACT_SEL: begin
          row_q <= '0;
          col_q <= '0;
        end
        ACT_NEXT: begin
          row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
          col_q <= '0;
        end
        ACT_WR:  col_q <= col_q + 1'b1;
        default: ;
      endcase
    end
  end

  // R1
  row_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_q <= ROW_LAST);
  // R3
  col_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q <= COL_FULL);
  // R3
  full_line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !sel_i && !next_line_i && col_q == COL_FULL)
      |=> ($stable(col_q) && $stable(row_q)));
  // R4
  sel_home_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |=> (row_q == '0 && col_q == '0));
  // R5
  next_col_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_line_i && !sel_i) |=> (col_q == '0));
  // R5
  wrap_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_line_i && !sel_i && row_q == ROW_LAST) |=> (row_q == '0));
endmodule

// File: rtl/led_grid_store.sv
module led_grid_store #(
  parameter int NPIX  = 25,
  parameter int LVL_W = 4,
  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_vld_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [LVL_W-1:0]           wr_lvl_i,
  output logic [NPIX-1:0][LVL_W-1:0] lvl_o
);
  logic [NPIX-1:0] we;

  for (genvar i = 0; i < NPIX; i++) begin : g_pix
    assign we[i] = wr_vld_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    lvl_o[i] <= '0;
      else if (we[i]) lvl_o[i] <= wr_lvl_i;
    end
  end

  // R2
  single_pixel_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we));
  // R2
  pixel_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_i |-> ($countones(we) == 1));
endmodule

// File: rtl/led_grid_pwm_gen.sv
module led_grid_pwm_gen #(
  parameter int NPIX  = 25,
  parameter int LVL_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NPIX-1:0][LVL_W-1:0] lvl_i,
  output logic [NPIX-1:0]            light_o
);
  logic [LVL_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + 1'b1;
  end

  for (genvar i = 0; i < NPIX; i++) begin : g_out
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) light_o[i] <= 1'b0;
      else         light_o[i] <= (phase_q < lvl_i[i]);
    end

    // R6
    zero_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lvl_i[i] == '0 && $stable(lvl_i[i])) |=> !light_o[i]);
  end

  // R6
  phase_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == '1) |=> (phase_q == '0));
endmodule

// File: rtl/led_grid_pwm.sv
module led_grid_pwm #(
  parameter int ROWS   = 5,
  parameter int COLS   = 5,
  parameter int LVL_W  = 4,
  parameter int DATA_W = 8,
  localparam int NPIX  = ROWS * COLS,
  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              next_line_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NPIX-1:0]   light_o
);
  logic                       wr_vld;
  logic [IDX_W-1:0]           wr_idx;
  logic [NPIX-1:0][LVL_W-1:0] lvl;
  logic                       unused_hi;

  // high data bits carry nothing
  assign unused_hi = ^wr_data_i[DATA_W-1:LVL_W];

  led_grid_ptr #(.ROWS(ROWS), .COLS(COLS)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_i),
    .next_line_i (next_line_i),
    .wr_en_i     (wr_en_i),
    .wr_vld_o    (wr_vld),
    .wr_idx_o    (wr_idx)
  );

  led_grid_store #(.NPIX(NPIX), .LVL_W(LVL_W)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_vld_i (wr_vld),
    .wr_idx_i (wr_idx),
    .wr_lvl_i (wr_data_i[LVL_W-1:0]),
    .lvl_o    (lvl)
  );

  led_grid_pwm_gen #(.NPIX(NPIX), .LVL_W(LVL_W)) u_pwm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl_i   (lvl),
    .light_o (light_o)
  );

  // R1
  reset_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (light_o == '0));
endmodule

// File: tb/led_grid_pwm_tb.sv
module led_grid_pwm_tb;
  localparam int NPIX = 25;
  localparam int NV   = 28;
  // op in [9:8]: 0 write, 1 next line, 2 select, 3 measure
  localparam logic [9:0] VEC [NV] = '{
    10'h200, 10'h001, 10'h012, 10'h0F3, 10'h004, 10'h005, 10'h00F,
    10'h100, 10'h006, 10'h007, 10'h100, 10'h00F, 10'h000, 10'h0AE,
    10'h300, 10'h100, 10'h100, 10'h009, 10'h100, 10'h00A, 10'h300,
    10'h200, 10'h00B, 10'h100, 10'h00C, 10'h0FF, 10'h000, 10'h300
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, nxt = 1'b0, wr = 1'b0;
  logic [7:0] dat = '0;
  logic [NPIX-1:0] light;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  int mdl_lvl [NPIX];
  int mdl_row = 0, mdl_col = 0;

  always #2 clk = ~clk;

  led_grid_pwm u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .next_line_i(nxt),
    .wr_en_i(wr), .wr_data_i(dat), .light_o(light)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_op(input logic s, input logic n, input logic w, input logic [7:0] d);
    @(negedge clk);
    sel = s; nxt = n; wr = w; dat = d;
    if (s) begin
      mdl_row = 0; mdl_col = 0;
    end else if (n) begin
      mdl_row = (mdl_row == 4) ? 0 : mdl_row + 1;
      mdl_col = 0;
    end else if (w && mdl_col < 5) begin
      mdl_lvl[mdl_row*5 + mdl_col] = int'(d[3:0]);
      mdl_col++;
    end
    @(negedge clk);
    sel = 0; nxt = 0; wr = 0; dat = '0;
  endtask

  task automatic measure(input string tag);
    int cnt [NPIX];
    int nest_err = 0;
    for (int i = 0; i < NPIX; i++) cnt[i] = 0;
    repeat (2) @(negedge clk);
    for (int t = 0; t < 16; t++) begin
      @(negedge clk);
      for (int i = 0; i < NPIX; i++) begin
        if (light[i]) cnt[i]++;
        for (int j = 0; j < NPIX; j++)
          if (light[i] && mdl_lvl[j] >= mdl_lvl[i] && !light[j]) nest_err++;
      end
    end
    for (int i = 0; i < NPIX; i++)
      chk(tag, cnt[i], mdl_lvl[i], $sformatf("duty of light %0d", i));
    chk("R7", nest_err, 0, "phase nesting violations");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    for (int i = 0; i < NPIX; i++) mdl_lvl[i] = 0;
    mdl_row = 0; mdl_col = 0;
    repeat (2) @(negedge clk);
    chk("R1", int'(light), 0, "lights during reset");
    rst_n = 1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R6 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1", int'(light), 0, "lights after reset");
    measure("R1");

    // table walk: R2 nibble/position, R3 full line, R5 wrap, R6 level 15
    for (int v = 0; v < NV; v++) begin
      case (VEC[v][9:8])
        2'd0: do_op(0, 0, 1, VEC[v][7:0]);
        2'd1: do_op(0, 1, 0, 8'h00);
        2'd2: do_op(1, 0, 0, 8'h00);
        default: measure("R2");
      endcase
    end

    // R4: select with write and next in same cycle: both dropped, home
    do_op(1, 1, 1, 8'h07);
    do_op(0, 0, 1, 8'h03);
    measure("R4");

    // R5: next-line with write in same cycle drops the write
    do_op(0, 1, 1, 8'h0D);
    do_op(0, 0, 1, 8'h08);
    measure("R5");

    // R5: five next-line strobes wrap to line 1
    do_op(1, 0, 0, 8'h00);
    for (int k = 0; k < 5; k++) do_op(0, 1, 0, 8'h00);
    do_op(0, 0, 1, 8'h0F);
    do_op(0, 0, 1, 8'h00);
    measure("R5");

    // R3: extra writes on a full line after re-select leave line 1 intact
    do_op(1, 0, 0, 8'h00);
    for (int k = 0; k < 5; k++) do_op(0, 0, 1, 8'h0F);
    do_op(0, 0, 1, 8'h02);
    do_op(0, 0, 1, 8'h01);
    measure("R3");

    // R1: reset mid-run clears all levels
    do_reset();
    measure("R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule